// File: doc/BRIEF.md
# Floating-Point Compare to Condition Field

This block compares two floating-point operands and records the outcome in one 4-bit field of a 32-bit condition register. It handles three operand formats: a single-precision scalar held in the low 32 bits of each operand, a packed pair of single-precision lanes (high lane in bits 63:32, low lane in bits 31:0), and a double-precision scalar that uses all 64 bits. A 4-bit relation code selects an equal, greater-than or less-than test. A 3-bit index picks the field to overwrite, and the other seven fields keep their values.

The compare logic is combinational. The condition register and the invalid-operation flag are clocked. A valid strobe starts an update. For a scalar, the field records whether the relation held. For a packed pair, the field holds both lane results and also their OR and their AND, so that one branch can test "either lane" or "both lanes". When a compare is unordered and one of its operands is a signaling NaN, the block raises an invalid-operation flag for one cycle. Quiet NaNs do not raise the flag.

Top module: `fcmp_crf`

## Requirements
- R1: While reset is asserted, and after its release, the condition register output is 32'h0000_0000 and the invalid flag is 0 until the first accepted compare.
- R2: Each operand pair is ordered as less, equal or greater by numeric value. Negative values order below positive values, larger magnitudes order lower among negative values, and +0 equals -0.
- R3: The relation code 4'hE tests equal, 4'hC tests greater-than (a > b) and 4'hD tests less-than (a < b). The format code is 2'b00 for a single scalar, 2'b01 for a packed pair and 2'b10 for a double scalar. A scalar compare writes 4'b0100 when the relation holds and 4'b0000 when it does not.
- R4: When either operand is a NaN (all-ones exponent and nonzero fraction), the result is unordered and satisfies no relation. For a scalar, the field becomes 4'b0000.
- R5: A packed-pair compare evaluates the high lane result ch (bits 63:32) and the low lane result cl (bits 31:0) separately. It writes the field {ch, cl, ch|cl, ch&cl}, with ch in the field's most significant bit.
- R6: A double scalar compare orders the full 64-bit operands, including values that the single-precision lanes cannot represent.
- R7: Field k occupies condition register bits [31-4k : 28-4k], so field 0 is the top nibble. Only the selected field changes on an accepted compare.
- R8: The cycle after an accepted compare, the invalid flag is 1 exactly when a compared lane is unordered and one of its operands is a signaling NaN (fraction MSB 0). A quiet NaN (fraction MSB 1) leaves the flag at 0. The flag returns to 0 on the next cycle unless another such compare follows.
- R9: With valid low, with a relation code other than C, D or E, or with format 2'b11, the condition register keeps its value and the invalid flag reads 0 the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request strobe; an update occurs on the next rising edge |
| rel_i | input | 4 | Relation code: E equal, C greater, D less |
| fmt_i | input | 2 | Operand format: 0 single, 1 packed pair, 2 double |
| field_i | input | 3 | Target field index, 0 = most significant nibble |
| opa_i | input | 64 | First operand bit pattern |
| opb_i | input | 64 | Second operand bit pattern |
| cr_o | output | 32 | Condition register |
| invalid_o | output | 1 | Invalid-operation flag for the previous accepted compare |

## Verification
The assertions check the following on every cycle:
- Untouched fields keep their value.
- An idle cycle leaves the register unchanged.
- A scalar field holds at most one set bit.
- An unordered scalar clears its field.
- A packed-pair field keeps its OR/AND consistency.
- The invalid flag only ever follows an accepted unordered compare.

Only the bench scenarios can show that the chosen relation gives the correct numeric answer. These scenarios cover signed zeros, negative magnitudes, infinities and doubles that fall outside single range. They also show that signaling and quiet NaNs are told apart, and that each lane lands in the correct bit of the pair encoding.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  typedef enum logic [1:0] {
    ORD_LT = 2'd0,
    ORD_EQ = 2'd1,
    ORD_GT = 2'd2,
    ORD_UN = 2'd3
  } order_e;

  typedef enum logic [1:0] {
    FMT_SGL  = 2'd0,
    FMT_PAIR = 2'd1,
    FMT_DBL  = 2'd2,
    FMT_RSV  = 2'd3
  } fmt_e;

  localparam logic [3:0] REL_GT = 4'hC;
  localparam logic [3:0] REL_LT = 4'hD;
  localparam logic [3:0] REL_EQ = 4'hE;
  localparam logic [3:0] NIB_HIT = 4'b0100;
endpackage

// File: rtl/fcmp_lane.sv
module fcmp_lane
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output order_e       ord_o,
  output logic         snan_o
);
  logic             a_s, b_s;
  logic [EXP_W-1:0] a_e, b_e;
  logic [MAN_W-1:0] a_m, b_m;
  logic [W-2:0]     a_mag, b_mag;
  logic             a_nan, b_nan, both_zero, mag_lt;

  always_comb begin
    a_s   = a_i[W-1];
    b_s   = b_i[W-1];
    a_e   = a_i[W-2 -: EXP_W];
    b_e   = b_i[W-2 -: EXP_W];
    a_m   = a_i[MAN_W-1:0];
    b_m   = b_i[MAN_W-1:0];
    a_mag = a_i[W-2:0];
    b_mag = b_i[W-2:0];
    a_nan = (&a_e) && (|a_m);
    b_nan = (&b_e) && (|b_m);
    both_zero = (a_mag == '0) && (b_mag == '0);
    mag_lt = a_mag < b_mag;
    snan_o = (a_nan && !a_m[MAN_W-1]) || (b_nan && !b_m[MAN_W-1]);
  end

  always_comb begin
    if (a_nan || b_nan)          ord_o = ORD_UN;
    else if (both_zero)          ord_o = ORD_EQ;
    else if (a_s != b_s)         ord_o = a_s ? ORD_LT : ORD_GT;
    else if (a_mag == b_mag)     ord_o = ORD_EQ;
    else if (mag_lt ^ a_s)       ord_o = ORD_LT;
    else                         ord_o = ORD_GT;
  end
endmodule

// File: rtl/fcmp_rel_eval.sv
module fcmp_rel_eval
  import fcmp_pkg::*;
(
  input  order_e     ord_i,
  input  logic [3:0] rel_i,
  output logic       hit_o
);
  always_comb begin
    unique case (rel_i)
      REL_EQ:  hit_o = (ord_i == ORD_EQ);
      REL_GT:  hit_o = (ord_i == ORD_GT);
      REL_LT:  hit_o = (ord_i == ORD_LT);
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/fcmp_field_ins.sv
module fcmp_field_ins #(
  parameter int FIELDS = 8,
  parameter int NIB_W  = 4,
  localparam int WORD_W = FIELDS * NIB_W,
  localparam int IDX_W  = $clog2(FIELDS)
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [NIB_W-1:0]  nib_i,
  output logic [WORD_W-1:0] word_o
);
  for (genvar f = 0; f < FIELDS; f++) begin : g_field
    assign word_o[(FIELDS-1-f)*NIB_W +: NIB_W] =
      (idx_i == IDX_W'(f)) ? nib_i : word_i[(FIELDS-1-f)*NIB_W +: NIB_W];
  end
endmodule

// File: rtl/fcmp_crf.sv
module fcmp_crf
  import fcmp_pkg::*;
#(
  parameter int SGL_EXP   = 8,
  parameter int SGL_MAN   = 23,
  parameter int DBL_EXP   = 11,
  parameter int DBL_MAN   = 52,
  parameter int CR_FIELDS = 8,
  localparam int SGL_W = 1 + SGL_EXP + SGL_MAN,
  localparam int DBL_W = 1 + DBL_EXP + DBL_MAN,
  localparam int NIB_W = 4,
  localparam int CR_W  = CR_FIELDS * NIB_W,
  localparam int IDX_W = $clog2(CR_FIELDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic [3:0]       rel_i,
  input  logic [1:0]       fmt_i,
  input  logic [IDX_W-1:0] field_i,
  input  logic [DBL_W-1:0] opa_i,
  input  logic [DBL_W-1:0] opb_i,
  output logic [CR_W-1:0]  cr_o,
  output logic             invalid_o
);
  // Lane 0 = low single word, lane 1 = high single word.
  order_e     sgl_ord  [2];
  logic [1:0] sgl_snan;
  logic [1:0] sgl_hit;
  order_e     dbl_ord;
  logic       dbl_snan;
  logic       dbl_hit;

  for (genvar g = 0; g < 2; g++) begin : g_sgl
    fcmp_lane #(.EXP_W(SGL_EXP), .MAN_W(SGL_MAN)) u_lane (
      .a_i   (opa_i[g*SGL_W +: SGL_W]),
      .b_i   (opb_i[g*SGL_W +: SGL_W]),
      .ord_o (sgl_ord[g]),
      .snan_o(sgl_snan[g])
    );
    fcmp_rel_eval u_rel (
      .ord_i(sgl_ord[g]),
      .rel_i(rel_i),
      .hit_o(sgl_hit[g])
    );
  end

  fcmp_lane #(.EXP_W(DBL_EXP), .MAN_W(DBL_MAN)) u_dbl (
    .a_i   (opa_i),
    .b_i   (opb_i),
    .ord_o (dbl_ord),
    .snan_o(dbl_snan)
  );
  fcmp_rel_eval u_dbl_rel (
    .ord_i(dbl_ord),
    .rel_i(rel_i),
    .hit_o(dbl_hit)
  );

  // Request decode
  logic rel_ok, fmt_ok, accept;
  fmt_e fmt;
  always_comb begin
    fmt    = fmt_e'(fmt_i);
    rel_ok = (rel_i == REL_EQ) || (rel_i == REL_GT) || (rel_i == REL_LT);
    fmt_ok = (fmt != FMT_RSV);
    accept = valid_i && rel_ok && fmt_ok;
  end

  // Field value and invalid condition
  logic [NIB_W-1:0] nib;
  logic             inv_hit;
  logic             any_un;
  always_comb begin
    nib     = '0;
    inv_hit = 1'b0;
    any_un  = 1'b0;
    unique case (fmt)
      FMT_SGL: begin
        nib     = sgl_hit[0] ? NIB_HIT : 4'b0000;
        any_un  = (sgl_ord[0] == ORD_UN);
        inv_hit = any_un && sgl_snan[0];
      end
      FMT_PAIR: begin
        nib     = {sgl_hit[1], sgl_hit[0], sgl_hit[1] | sgl_hit[0], sgl_hit[1] & sgl_hit[0]};
        any_un  = (sgl_ord[0] == ORD_UN) || (sgl_ord[1] == ORD_UN);
        inv_hit = ((sgl_ord[0] == ORD_UN) && sgl_snan[0]) ||
                  ((sgl_ord[1] == ORD_UN) && sgl_snan[1]);
      end
      FMT_DBL: begin
        nib     = dbl_hit ? NIB_HIT : 4'b0000;
        any_un  = (dbl_ord == ORD_UN);
        inv_hit = any_un && dbl_snan;
      end
      default: begin
        nib     = '0;
        any_un  = 1'b0;
        inv_hit = 1'b0;
      end
    endcase
  end

  logic [CR_W-1:0] cr_q, cr_ins, cr_d;
  logic            inv_q, inv_d;

  fcmp_field_ins #(.FIELDS(CR_FIELDS), .NIB_W(NIB_W)) u_ins (
    .word_i(cr_q),
    .idx_i (field_i),
    .nib_i (nib),
    .word_o(cr_ins)
  );

  // Next state
  always_comb begin
    cr_d  = accept ? cr_ins : cr_q;
    inv_d = accept && inv_hit;
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr_q  <= '0;
      inv_q <= 1'b0;
    end else begin
      cr_q  <= cr_d;
      inv_q <= inv_d;
    end
  end

  assign cr_o      = cr_q;
  assign invalid_o = inv_q;

  // Checks
  function automatic logic [CR_W-1:0] field_mask(input logic [IDX_W-1:0] k);
    return {{(CR_W-NIB_W){1'b0}}, {NIB_W{1'b1}}} << ((CR_FIELDS - 1 - int'(k)) * NIB_W);
  endfunction

  function automatic logic [NIB_W-1:0] nib_at(input logic [CR_W-1:0] w, input logic [IDX_W-1:0] k);
    logic [CR_W-1:0] t;
    t = w >> ((CR_FIELDS - 1 - int'(k)) * NIB_W);
    return t[NIB_W-1:0];
  endfunction

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> ($stable(cr_o) && !invalid_o));

  p_other_fields_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ((cr_o & ~$past(field_mask(field_i))) == ($past(cr_o) & ~$past(field_mask(field_i)))));

  p_scalar_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && fmt != FMT_PAIR) |=> ($countones(nib_at(cr_o, $past(field_i))) <= 1));

  p_unordered_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && fmt != FMT_PAIR && any_un) |=> (nib_at(cr_o, $past(field_i)) == 4'b0000));

  p_pair_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && fmt == FMT_PAIR) |=>
      ((nib_at(cr_o, $past(field_i)) & 4'b0011) ==
       {1'b0, 1'b0, nib_at(cr_o, $past(field_i))[3] | nib_at(cr_o, $past(field_i))[2],
        nib_at(cr_o, $past(field_i))[3] & nib_at(cr_o, $past(field_i))[2]}));

  p_invalid_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_o |-> ($past(accept) && $past(any_un)));
endmodule

// File: tb/tb_fcmp_crf.sv
`timescale 1ns/1ps
module tb_fcmp_crf;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid_i;
  logic [3:0]  rel_i;
  logic [1:0]  fmt_i;
  logic [2:0]  field_i;
  logic [63:0] opa_i, opb_i;
  logic [31:0] cr_o;
  logic        invalid_o;

  always #10 clk = ~clk;

  fcmp_crf dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .rel_i(rel_i), .fmt_i(fmt_i),
    .field_i(field_i), .opa_i(opa_i), .opb_i(opb_i), .cr_o(cr_o), .invalid_o(invalid_o)
  );

  typedef struct {
    logic [31:0] cr;
    logic        inv;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] cr_model = 32'h0;
  bit          done = 1'b0;

  // Model: 0 less, 1 equal, 2 greater, 3 unordered
  function automatic int ord_sgl(input logic [31:0] a, input logic [31:0] b);
    longint ka, kb;
    if ((a[30:23] == 8'hFF && a[22:0] != 0) || (b[30:23] == 8'hFF && b[22:0] != 0)) return 3;
    ka = a[31] ? -longint'(a[30:0]) : longint'(a[30:0]);
    kb = b[31] ? -longint'(b[30:0]) : longint'(b[30:0]);
    if (ka < kb) return 0;
    if (ka == kb) return 1;
    return 2;
  endfunction

  function automatic int ord_dbl(input logic [63:0] a, input logic [63:0] b);
    real ra, rb;
    if ((a[62:52] == 11'h7FF && a[51:0] != 0) || (b[62:52] == 11'h7FF && b[51:0] != 0)) return 3;
    ra = $bitstoreal(a);
    rb = $bitstoreal(b);
    if (ra < rb) return 0;
    if (ra == rb) return 1;
    return 2;
  endfunction

  function automatic bit snan_s(input logic [31:0] x);
    return x[30:23] == 8'hFF && x[22:0] != 0 && !x[22];
  endfunction

  function automatic bit snan_d(input logic [63:0] x);
    return x[62:52] == 11'h7FF && x[51:0] != 0 && !x[51];
  endfunction

  function automatic bit rel_hit(input int o, input logic [3:0] r);
    case (r)
      4'hE: return o == 1;
      4'hC: return o == 2;
      4'hD: return o == 0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic apply(input logic [1:0] f, input logic [3:0] r, input logic [2:0] k,
                       input logic [63:0] a, input logic [63:0] b, input string tag);
    exp_t e;
    bit ok, inv, ch, cl;
    int oh, ol;
    logic [3:0] nib;
    ok  = (r == 4'hC || r == 4'hD || r == 4'hE) && f != 2'b11;
    inv = 1'b0;
    nib = 4'b0000;
    if (f == 2'b00) begin
      ol  = ord_sgl(a[31:0], b[31:0]);
      nib = rel_hit(ol, r) ? 4'b0100 : 4'b0000;
      inv = (ol == 3) && (snan_s(a[31:0]) || snan_s(b[31:0]));
    end else if (f == 2'b01) begin
      ol  = ord_sgl(a[31:0], b[31:0]);
      oh  = ord_sgl(a[63:32], b[63:32]);
      ch  = rel_hit(oh, r);
      cl  = rel_hit(ol, r);
      nib = {ch, cl, ch | cl, ch & cl};
      inv = ((ol == 3) && (snan_s(a[31:0]) || snan_s(b[31:0]))) ||
            ((oh == 3) && (snan_s(a[63:32]) || snan_s(b[63:32])));
    end else if (f == 2'b10) begin
      ol  = ord_dbl(a, b);
      nib = rel_hit(ol, r) ? 4'b0100 : 4'b0000;
      inv = (ol == 3) && (snan_d(a) || snan_d(b));
    end
    if (ok) cr_model[31-4*k -: 4] = nib;
    e.cr  = cr_model;
    e.inv = ok && inv;
    e.tag = tag;
    @(negedge clk);
    valid_i = 1'b1; rel_i = r; fmt_i = f; field_i = k; opa_i = a; opb_i = b;
    sb.push_back(e);
  endtask

  task automatic chk32(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cr actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic chk1(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s invalid actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Monitor: pop one expectation per accepted strobe
  initial begin
    forever begin
      @(posedge clk);
      if (rst_n === 1'b1 && valid_i === 1'b1) begin
        exp_t e;
        @(negedge clk);
        if (sb.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL scoreboard underflow actual=empty expected=item");
        end else begin
          e = sb.pop_front();
          chk32(cr_o, e.cr, e.tag);
          chk1(invalid_o, e.inv, e.tag);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  localparam logic [31:0] S_ONE = 32'h3F80_0000, S_TWO = 32'h4000_0000;
  localparam logic [31:0] S_M1 = 32'hBF80_0000, S_M2 = 32'hC000_0000;
  localparam logic [31:0] S_PZ = 32'h0000_0000, S_NZ = 32'h8000_0000;
  localparam logic [31:0] S_QN = 32'h7FC0_0000, S_SN = 32'h7F80_0001, S_INF = 32'h7F80_0000;
  localparam logic [63:0] D_ONE = 64'h3FF0_0000_0000_0000, D_MH = 64'hBFE0_0000_0000_0000;
  localparam logic [63:0] D_INF = 64'h7FF0_0000_0000_0000, D_SN = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] D_QN = 64'h7FF8_0000_0000_0000, D_BIG = 64'h4800_0000_0000_0000;
  localparam logic [63:0] D_BIG2 = 64'h4800_0000_0000_0001;

  initial begin
    rst_n = 1'b0; valid_i = 1'b0; rel_i = 4'h0; fmt_i = 2'b00; field_i = 3'd0;
    opa_i = '0; opb_i = '0;
    repeat (3) @(negedge clk);
    chk32(cr_o, 32'h0, "R1 in reset");
    chk1(invalid_o, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk32(cr_o, 32'h0, "R1 after release");
    chk1(invalid_o, 1'b0, "R1 after release");

    // Scalar single
    apply(2'b00, 4'hE, 3'd0, {32'h0, S_ONE}, {32'h0, S_ONE}, "R3 eq 1==1 field0");
    apply(2'b00, 4'hC, 3'd7, {32'h0, S_TWO}, {32'h0, S_ONE}, "R3 gt 2>1 field7");
    apply(2'b00, 4'hD, 3'd1, {32'h0, S_M1}, {32'h0, S_M2}, "R2 lt -1<-2 false");
    apply(2'b00, 4'hC, 3'd2, {32'h0, S_M1}, {32'h0, S_M2}, "R2 gt -1>-2 true");
    apply(2'b00, 4'hE, 3'd3, {32'h0, S_PZ}, {32'h0, S_NZ}, "R2 +0==-0");
    apply(2'b00, 4'hD, 3'd4, {32'h0, S_M1}, {32'h0, S_ONE}, "R2 lt -1<1");
    apply(2'b00, 4'hC, 3'd5, {32'h0, S_INF}, {32'h0, S_TWO}, "R2 inf>2");
    apply(2'b00, 4'hE, 3'd0, {32'h0, S_QN}, {32'h0, S_QN}, "R4 qnan eq clears no flag R8");
    apply(2'b00, 4'hC, 3'd7, {32'h0, S_ONE}, {32'h0, S_SN}, "R8 snan raises flag R4");
    apply(2'b00, 4'hD, 3'd6, {32'h0, S_ONE}, {32'h0, S_TWO}, "R8 flag drops after");
    // Packed pair
    apply(2'b01, 4'hC, 3'd1, {S_TWO, S_ONE}, {S_ONE, S_TWO}, "R5 pair hi only");
    apply(2'b01, 4'hC, 3'd2, {S_ONE, S_TWO}, {S_TWO, S_ONE}, "R5 pair lo only");
    apply(2'b01, 4'hE, 3'd3, {S_ONE, S_PZ}, {S_ONE, S_NZ}, "R5 pair both");
    apply(2'b01, 4'hD, 3'd4, {S_ONE, S_ONE}, {S_ONE, S_ONE}, "R5 pair none");
    apply(2'b01, 4'hE, 3'd5, {S_SN, S_ONE}, {S_ONE, S_ONE}, "R8 pair hi snan");
    apply(2'b01, 4'hE, 3'd6, {S_QN, S_ONE}, {S_ONE, S_ONE}, "R8 pair hi qnan no flag");
    // Double
    apply(2'b10, 4'hC, 3'd0, D_ONE, D_MH, "R6 dbl 1>-0.5");
    apply(2'b10, 4'hD, 3'd1, D_BIG, D_BIG2, "R6 dbl low-bit lt");
    apply(2'b10, 4'hE, 3'd2, D_INF, D_INF, "R6 dbl inf==inf");
    apply(2'b10, 4'hE, 3'd3, D_QN, D_ONE, "R4 dbl qnan");
    apply(2'b10, 4'hD, 3'd4, D_SN, D_ONE, "R8 dbl snan");
    // Field placement sweep
    for (int k = 0; k < 8; k++)
      apply(2'b00, 4'hE, 3'(k), {32'h0, S_ONE}, {32'h0, S_ONE}, "R7 field sweep");
    apply(2'b00, 4'hD, 3'd5, {32'h0, S_TWO}, {32'h0, S_ONE}, "R7 clear one field");
    // Ignored requests
    apply(2'b00, 4'h0, 3'd0, {32'h0, S_SN}, {32'h0, S_ONE}, "R9 bad relation");
    apply(2'b11, 4'hE, 3'd1, {32'h0, S_PZ}, {32'h0, S_PZ}, "R9 reserved format");
    @(negedge clk);
    valid_i = 1'b0; rel_i = 4'hE; fmt_i = 2'b00; field_i = 3'd2;
    opa_i = {32'h0, S_PZ}; opb_i = {32'h0, S_SN};
    @(negedge clk);
    @(negedge clk);
    chk32(cr_o, cr_model, "R9 valid low");
    chk1(invalid_o, 1'b0, "R9 valid low");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule